// File: doc/BRIEF.md
# Word Shifter with Carry

This block is the shifting part of a processor execution stage. It takes one 64-bit source operand and a 7-bit shift amount. It performs one of three operations: a logical left shift, a right shift (zero-filling or sign-filling), or a sign extension of the low word followed by a left shift. A mode flag picks between full 64-bit operation and 32-bit word operation. A signed flag picks an arithmetic right shift over a logical one.

The block returns four registered outputs, all updated on the same clock edge, one cycle after the operands are presented:

- the 64-bit result;
- a flag that is high only for a recognised operation code;
- a two-bit carry, in which both bits always carry the same value;
- an opaque context word, copied from the input without change.

Amounts at or beyond the data width are handled as defined shifts and are never wrapped. The carry is raised only by an arithmetic right shift of a negative value that loses at least one 1 bit.

Top module: `wshift_unit`

## Requirements
- R1: While the synchronous active-high reset is asserted, the next clock edge clears the result, the valid flag, both carry bits and the context output to zero.
- R2: Operation codes are 2'b00 left shift, 2'b01 right shift and 2'b10 sign-extend-word-then-left-shift. The valid flag is high for these three codes. For code 2'b11 the valid flag, the result and the carry are all zero.
- R3: With the mode flag low, a left shift uses all 7 amount bits. An amount of 64 or more gives a zero result.
- R4: With the mode flag high, a left shift uses only amount bits 5:0, so bit 6 is ignored. The result is the low 32 bits of the shifted source, and bits 63:32 are zero. An amount of 32 to 63 gives zero.
- R5: A logical right shift (signed flag low) fills with zeros. In 32-bit mode the source is the zero-extended low word and the amount is bits 5:0. In 64-bit mode the amount is all 7 bits. Amounts at or beyond the width give zero.
- R6: An arithmetic right shift (signed flag high) fills with copies of the sign. In 32-bit mode the sign is source bit 31: the low word is sign-extended to 64 bits before the shift, so bits 63:32 of the result hold sign copies. Amounts at or beyond the width give all sign copies.
- R7: On an arithmetic right shift, the carry is 1 exactly when the sign-extended source is negative and shifting the result back left by the same amount does not restore that source. Equivalently, at least one 1 bit was shifted out.
- R8: Left shifts, sign-extend-and-shift, and logical right shifts give carry 0.
- R9: Both carry bits always hold the same value.
- R10: Sign-extend-and-shift sign-extends source bits 31:0 to 64 bits and shifts left by amount bits 5:0. The mode flag and amount bit 6 have no effect on it.
- R11: The result, valid flag, carry and context output on each edge reflect the inputs sampled at that edge. The context output equals the context input of that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Operation code |
| w32_i | input | 1 | 32-bit word mode |
| sgn_i | input | 1 | Arithmetic (signed) right shift |
| src_i | input | 64 | Source operand |
| amt_i | input | 7 | Shift amount |
| ctx_i | input | 8 | Context word carried alongside |
| res_o | output | 64 | Shift result |
| ok_o | output | 1 | Operation code recognised |
| carry_o | output | 2 | Carry pair, both bits equal |
| ctx_o | output | 8 | Context word copied from the input |

## Verification
The result and the carry are produced in the same cycle by an arithmetic right shift. A wrong sign fill and a wrong carry can therefore appear together, or hide each other. The bench provokes both at once with negative sources and amounts of 0, 31, 32, 63, 64 and 127. It also uses a source whose low byte is zero, so that shifting by 8 loses only zeros while shifting by 9 loses a 1. The scoreboard judges result and carry as separate checks against a 128-bit reference that computes the carry from the shift-back comparison.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic [1:0] {
    WS_SHL   = 2'b00,
    WS_SHR   = 2'b01,
    WS_EXTSW = 2'b10,
    WS_RSV   = 2'b11
  } ws_op_e;
endpackage

// File: rtl/ws_amt_dec.sv
// Picks the effective shift amount for the current mode.
module ws_amt_dec #(
  parameter int AMT_W = 7
) (
  input  logic [AMT_W-1:0] amt_i,
  input  logic             w32_i,
  output logic [AMT_W-1:0] amt_o,
  output logic [AMT_W-2:0] amt_half_o
);
  // Word mode drops the top amount bit; 64-bit mode keeps every bit.
  assign amt_half_o = amt_i[AMT_W-2:0];
  assign amt_o      = w32_i ? {1'b0, amt_i[AMT_W-2:0]} : amt_i;
endmodule

// File: rtl/ws_left.sv
// Left shift and sign-extend-word-then-shift.
module ws_left #(
  parameter int DATA_W = 64,
  parameter int AMT_W  = 7
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [AMT_W-2:0]  amt_half_i,
  input  logic              w32_i,
  input  logic              ext_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] shl_full;
  logic [DATA_W-1:0] shl_res;
  logic [DATA_W-1:0] sx_src;
  logic [DATA_W-1:0] ext_res;

  always_comb begin
    // A shift count at or past the width yields zero in the operator itself.
    shl_full = src_i << amt_i;
    shl_res  = w32_i ? {{HALF{1'b0}}, shl_full[HALF-1:0]} : shl_full;
    sx_src   = {{HALF{src_i[HALF-1]}}, src_i[HALF-1:0]};
    ext_res  = sx_src << amt_half_i;
    res_o    = ext_i ? ext_res : shl_res;
  end
endmodule

// File: rtl/ws_right.sv
// Right shift (zero or sign fill) with lost-ones carry.
module ws_right #(
  parameter int DATA_W = 64,
  parameter int AMT_W  = 7
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              w32_i,
  input  logic              sgn_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  logic [DATA_W-1:0] src_w;
  logic              fill;
  logic [DATA_W-1:0] zshift;
  logic [DATA_W-1:0] fill_mask;
  logic [DATA_W-1:0] lost_mask;

  always_comb begin
    // Word mode widens the low half first, sign or zero as requested.
    src_w     = w32_i ? {{HALF{sgn_i & src_i[HALF-1]}}, src_i[HALF-1:0]} : src_i;
    fill      = sgn_i & src_w[DATA_W-1];
    zshift    = src_w >> amt_i;
    // Vacated top positions; all ones once the amount reaches the width.
    fill_mask = ~(ONES >> amt_i);
    // Positions that fall off the bottom.
    lost_mask = ~(ONES << amt_i);
    res_o     = zshift | (fill ? fill_mask : '0);
    carry_o   = fill & (|(src_w & lost_mask));
  end
endmodule

// File: rtl/wshift_unit.sv
module wshift_unit #(
  parameter int DATA_W = 64,
  parameter int CTX_W  = 8,
  parameter int AMT_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [1:0]        op_i,
  input  logic              w32_i,
  input  logic              sgn_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ok_o,
  output logic [1:0]        carry_o,
  output logic [CTX_W-1:0]  ctx_o
);
  import ws_pkg::*;

  ws_op_e            op;
  logic [AMT_W-1:0]  amt_eff;
  logic [AMT_W-2:0]  amt_half;
  logic [DATA_W-1:0] left_res;
  logic [DATA_W-1:0] right_res;
  logic              right_cy;
  logic [DATA_W-1:0] res_n;
  logic              ok_n;
  logic              cy_n;

  assign op = ws_op_e'(op_i);

  ws_amt_dec #(.AMT_W(AMT_W)) u_dec (
    .amt_i      (amt_i),
    .w32_i      (w32_i),
    .amt_o      (amt_eff),
    .amt_half_o (amt_half)
  );

  ws_left #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_left (
    .src_i      (src_i),
    .amt_i      (amt_eff),
    .amt_half_i (amt_half),
    .w32_i      (w32_i),
    .ext_i      (op == WS_EXTSW),
    .res_o      (left_res)
  );

  ws_right #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_right (
    .src_i   (src_i),
    .amt_i   (amt_eff),
    .w32_i   (w32_i),
    .sgn_i   (sgn_i),
    .res_o   (right_res),
    .carry_o (right_cy)
  );

  always_comb begin
    res_n = '0;
    ok_n  = 1'b0;
    cy_n  = 1'b0;
    unique case (op)
      WS_SHL, WS_EXTSW: begin
        res_n = left_res;
        ok_n  = 1'b1;
      end
      WS_SHR: begin
        res_n = right_res;
        ok_n  = 1'b1;
        cy_n  = right_cy;
      end
      default: begin
        res_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_o   <= '0;
      ok_o    <= 1'b0;
      carry_o <= 2'b00;
      ctx_o   <= '0;
    end else begin
      res_o   <= res_n;
      ok_o    <= ok_n;
      carry_o <= {cy_n, cy_n};
      ctx_o   <= ctx_i;
    end
  end
endmodule

// File: rtl/wshift_unit_chk.sv
module wshift_unit_chk #(
  parameter int DATA_W = 64,
  parameter int CTX_W  = 8,
  parameter int AMT_W  = 7
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [1:0]        op_i,
  input logic              w32_i,
  input logic              sgn_i,
  input logic [DATA_W-1:0] res_o,
  input logic              ok_o,
  input logic [1:0]        carry_o,
  input logic [CTX_W-1:0]  ctx_i,
  input logic [CTX_W-1:0]  ctx_o
);
  localparam int HALF = DATA_W / 2;

  p_rst_clear_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!ok_o && res_o == '0 && carry_o == 2'b00 && ctx_o == '0));

  p_ok_code_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    ok_o |-> ($past(op_i) != 2'b11));

  p_rsv_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == 2'b11) |-> (!ok_o && res_o == '0 && carry_o == 2'b00));

  p_shl_word_upper_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (ok_o && $past(op_i) == 2'b00 && $past(w32_i)) |-> (res_o[DATA_W-1:HALF] == '0));

  p_carry_source_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    carry_o[0] |-> ($past(op_i) == 2'b01 && $past(sgn_i)));

  p_carry_pair_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    carry_o[0] == carry_o[1]);

  p_ctx_follow_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (ctx_o == $past(ctx_i)));
endmodule

bind wshift_unit wshift_unit_chk #(.DATA_W(DATA_W), .CTX_W(CTX_W), .AMT_W(AMT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .op_i    (op_i),
  .w32_i   (w32_i),
  .sgn_i   (sgn_i),
  .res_o   (res_o),
  .ok_o    (ok_o),
  .carry_o (carry_o),
  .ctx_i   (ctx_i),
  .ctx_o   (ctx_o)
);

// File: tb/sim_wshift_unit.sv
`timescale 1ns/1ps
module sim_wshift_unit;
  localparam int DW = 64;
  localparam int CW = 8;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    op = 2'b00;
  logic          w32 = 1'b0;
  logic          sgn = 1'b0;
  logic [DW-1:0] src = '0;
  logic [AW-1:0] amt = '0;
  logic [CW-1:0] ctx = '0;
  logic [DW-1:0] res;
  logic          ok;
  logic [1:0]    cy;
  logic [CW-1:0] ctx_q;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [DW-1:0] res;
    logic          ok;
    logic          cy;
    logic [CW-1:0] ctx;
    string         rtag;
    string         ctag;
  } item_t;

  item_t sb[$];

  always #2.5 clk = ~clk;

  wshift_unit #(.DATA_W(DW), .CTX_W(CW)) u0 (
    .clk_i(clk), .rst_i(rst), .op_i(op), .w32_i(w32), .sgn_i(sgn),
    .src_i(src), .amt_i(amt), .ctx_i(ctx),
    .res_o(res), .ok_o(ok), .carry_o(cy), .ctx_o(ctx_q)
  );

  // Reference model, 128-bit arithmetic, written from the requirements.
  function automatic void model(input logic [1:0] o, input logic m32, input logic s,
                                input logic [63:0] v, input logic [6:0] a,
                                output logic [63:0] r, output logic vld, output logic c);
    logic signed [127:0] x;
    logic signed [127:0] y;
    logic [127:0] t;
    logic [63:0] e;
    int k;
    r = '0; vld = 1'b0; c = 1'b0;
    k = m32 ? int'(a[5:0]) : int'(a);
    case (o)
      2'b00: begin // R3 / R4
        t = {64'b0, v} << k;
        r = m32 ? {32'b0, t[31:0]} : t[63:0];
        vld = 1'b1;
      end
      2'b01: begin // R5 / R6 / R7
        if (m32) x = s ? {{96{v[31]}}, v[31:0]} : {96'b0, v[31:0]};
        else     x = s ? {{64{v[63]}}, v} : {64'b0, v};
        y = x >>> k;
        r = y[63:0];
        c = s && (x < 0) && ((y <<< k) != x);
        vld = 1'b1;
      end
      2'b10: begin // R10
        e = {{32{v[31]}}, v[31:0]};
        r = e << a[5:0];
        vld = 1'b1;
      end
      default: ;
    endcase
  endfunction

  task automatic drive(input logic [1:0] o, input logic m32, input logic s,
                       input logic [63:0] v, input logic [6:0] a);
    item_t it;
    logic [63:0] r;
    logic vld, c;
    @(negedge clk);
    op = o; w32 = m32; sgn = s; src = v; amt = a; ctx = ctx + 8'd37;
    model(o, m32, s, v, a, r, vld, c);
    it.res = r; it.ok = vld; it.cy = c; it.ctx = ctx;
    case (o)
      2'b00: it.rtag = m32 ? "R4" : "R3";
      2'b01: it.rtag = s ? "R6" : "R5";
      2'b10: it.rtag = "R10";
      default: it.rtag = "R2";
    endcase
    it.ctag = (o == 2'b01 && s) ? "R7" : "R8";
    sb.push_back(it);
  endtask

  // Monitor: outputs settle one edge after the driver's negedge.
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_run++;
      if (res !== it.res) begin
        n_fail++;
        $display("FAIL %s result act=%h exp=%h", it.rtag, res, it.res);
      end
      n_run++;
      if (cy[0] !== it.cy) begin
        n_fail++;
        $display("FAIL %s carry act=%b exp=%b", it.ctag, cy[0], it.cy);
      end
      n_run++;
      if (cy[0] !== cy[1]) begin
        n_fail++;
        $display("FAIL R9 carry pair act=%b exp=%b", cy, {cy[0], cy[0]});
      end
      n_run++;
      if (ok !== it.ok) begin
        n_fail++;
        $display("FAIL R2 valid act=%b exp=%b", ok, it.ok);
      end
      n_run++;
      if (ctx_q !== it.ctx) begin
        n_fail++;
        $display("FAIL R11 context act=%h exp=%h", ctx_q, it.ctx);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] pats [5];
    logic [6:0]  amts [7];
    pats[0] = 64'h8000_0000_F0F0_1234;
    pats[1] = 64'h0000_0000_8000_0000;
    pats[2] = 64'h1234_5678_7000_0001;
    pats[3] = 64'hFFFF_FFFF_FFFF_FF00;
    pats[4] = 64'h7FFF_FFFF_0000_0003;
    amts[0] = 7'd0;  amts[1] = 7'd31; amts[2] = 7'd32; amts[3] = 7'd63;
    amts[4] = 7'd64; amts[5] = 7'd127; amts[6] = 7'd69;

    op = 2'b01; sgn = 1'b1; src = '1; amt = 7'd5; ctx = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++; // R1 reset state
    if (res !== '0 || ok !== 1'b0 || cy !== 2'b00 || ctx_q !== '0) begin
      n_fail++;
      $display("FAIL R1 reset act=%h/%b/%b/%h exp=0/0/00/00", res, ok, cy, ctx_q);
    end
    rst = 1'b0;

    for (int o = 0; o < 4; o++)
      for (int m = 0; m < 2; m++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 5; p++)
            for (int k = 0; k < 7; k++)
              drive(2'(o), 1'(m), 1'(s), pats[p], amts[k]);

    // R7 corner: only zeros lost at 8, a one lost at 9.
    drive(2'b01, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FF00, 7'd8);
    drive(2'b01, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FF00, 7'd9);
    drive(2'b01, 1'b1, 1'b1, 64'h0000_0000_FFFF_FF00, 7'd8);
    drive(2'b01, 1'b1, 1'b1, 64'h0000_0000_FFFF_FF00, 7'd9);

    for (int i = 0; i < 600; i++)
      drive(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
            {$urandom, $urandom}, 7'($urandom));

    repeat (4) @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule